// File: doc/BRIEF.md
# Seconds Counter with Seven-Segment Output

This block counts elapsed seconds from 0 to 7 and shows the value on one seven-segment digit. An internal prescaler counts input clock cycles down from `TICK_CYCLES-1` to zero. When it reaches zero it produces a one-cycle tick and reloads. A 3-bit counter moves forward by one only on cycles where that tick is present. A decoder turns the count into an active-low segment pattern.

The `run` input pauses and resumes counting. It is sampled on the rising clock edge. While it is low, both the count and the prescaler phase are frozen, so a partly elapsed second is kept across a pause. The active-low reset is asynchronous. It clears the count and reloads the prescaler. The default `TICK_CYCLES` of 10 gives one step per second from a 10 Hz clock.

Top module: `sec_seg_counter`

## Requirements
- R1: After reset is released, with `run` held high, the count first becomes 1 on the `TICK_CYCLES`-th rising edge and not before.
- R2: Once a step has happened, the next step happens exactly `TICK_CYCLES` enabled edges later, because the prescaler reloads `TICK_CYCLES-1` after its zero cycle.
- R3: The count changes only on a rising edge where `run` is high and the prescaler is at zero. The change is always +1.
- R4: While `run` is low, the displayed count does not change. The prescaler phase is also kept: enabled edges before and after a pause add up toward the next step.
- R5: After 7, the next step gives 0.
- R6: While `rst_n` is low, the display shows 0 at once, without waiting for a clock edge, and stays at 0 across clock edges.
- R7: Reset reloads the prescaler. After a mid-second reset, the first step again takes a full `TICK_CYCLES` enabled edges.
- R8: `seg_n` is active-low, with bit 0 = segment a through bit 6 = segment g. The value is {g..a} = 0:1000000, 1:1111001, 2:0100100, 3:0110000, 4:0011001, 5:0010010, 6:0000010, 7:1111000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Synchronous active-high count enable |
| seg_n | output | 7 | Active-low segments, bit 0 = a … bit 6 = g |

## Verification
The prescaler can only be seen through the time at which the digit changes. A wrong reload value or a wrong decrement therefore shows up as a step one or more cycles early or late. Every step boundary is sampled on the cycle just before it and on the cycle of it. A lost pause phase shows up as a late step on the first second after `run` returns high. A bad wrap or bad segment pattern shows up as a wrong digit on the very step where it occurs.

// File: rtl/sec_seg_counter.sv
module sec_seg_counter #(
  parameter int TICK_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic [6:0] seg_n
);
  localparam int DW = (TICK_CYCLES < 2) ? 1 : $clog2(TICK_CYCLES);
  localparam logic [DW-1:0] RELOAD = DW'(TICK_CYCLES - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    cnt_q;
  logic          tick;

  assign tick = ~|div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= RELOAD;
      cnt_q <= '0;
    end else if (run) begin
      if (tick) begin
        div_q <= RELOAD;
        cnt_q <= cnt_q + 3'd1;
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (cnt_q)
      3'd0: seg_n = 7'b1000000;
      3'd1: seg_n = 7'b1111001;
      3'd2: seg_n = 7'b0100100;
      3'd3: seg_n = 7'b0110000;
      3'd4: seg_n = 7'b0011001;
      3'd5: seg_n = 7'b0010010;
      3'd6: seg_n = 7'b0000010;
      default: seg_n = 7'b1111000;
    endcase
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n) div_q <= RELOAD); // R2
  AST_DIV_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) run && tick |=> div_q == RELOAD); // R2
  AST_DIV_DECR: assert property (@(posedge clk) disable iff (!rst_n) run && !tick |=> div_q == $past(div_q) - 1'b1); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) run && tick |=> cnt_q == $past(cnt_q) + 3'd1); // R3
  AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n) !(run && tick) |=> $stable(cnt_q)); // R3
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(div_q) && $stable(cnt_q)); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n) run && tick && cnt_q == 3'd7 |=> cnt_q == 3'd0); // R5
endmodule

// File: tb/sec_seg_counter_tb_top.sv
module sec_seg_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [6:0] seg_n;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sec_seg_counter #(.TICK_CYCLES(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .seg_n(seg_n)
  );

  function automatic logic [6:0] pat(input int d);
    logic [6:0] p [8] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78};
    return p[d % 8];
  endfunction

  task automatic chk(input string req, input int exp_d);
    n_run++;
    if (seg_n !== pat(exp_d)) begin
      n_fail++;
      $display("FAIL %s: seg_n=%b expected %b (digit %0d)", req, seg_n, pat(exp_d), exp_d);
    end
  endtask

  task automatic step(input logic r, input int n);
    run = r;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // {run, cycles, expected digit, requirement}
  typedef struct { logic r; int n; int d; string req; } vec_t;
  localparam int NV = 10;
  vec_t vt [NV] = '{
    '{1'b1,  9, 0, "R1"}, '{1'b1,  1, 1, "R1"},
    '{1'b0, 25, 1, "R4"}, '{1'b1, 10, 2, "R2"},
    '{1'b1,  5, 2, "R3"}, '{1'b0,  7, 2, "R4"},
    '{1'b1,  5, 3, "R4"}, '{1'b1, 40, 7, "R3"},
    '{1'b1, 10, 0, "R5"}, '{1'b1, 10, 1, "R5"}
  };

  initial begin
    #3 chk("R6", 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6", 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(vt[i].r, vt[i].n);
      chk(vt[i].req, vt[i].d);
    end
    // R8: walk all digits, checking the edge before and the edge of each step
    for (int d = 2; d < 10; d++) begin
      step(1'b1, 9);
      chk("R2", d - 1);
      step(1'b1, 1);
      chk("R8", d);
    end
    // R6: asynchronous clear in mid-cycle, held over edges
    step(1'b1, 13);
    #1 rst_n = 1'b0;
    #1 chk("R6", 0);
    step(1'b1, 3);
    chk("R6", 0);
    rst_n = 1'b1;
    // R7: a full period is needed after reset
    step(1'b1, 9);
    chk("R7", 0);
    step(1'b1, 1);
    chk("R7", 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule